// File: doc/BRIEF.md
# Reciprocal square root estimator

This unit produces a coarse seed for 1/sqrt(x), accurate to about eight fraction bits, in one of two modes. In floating mode it takes a binary32 operand and returns a binary32 estimate plus two exception flags, invalid-operation and divide-by-zero. In fixed mode it takes a 32-bit unsigned fraction and returns a 32-bit unsigned fraction estimate, with both flags held low. The seed is meant to feed later refinement steps elsewhere in a datapath. Those steps are not part of this block.

The operand is first normalised into one of two ranges, chosen by the parity of its exponent: [0.25, 0.5) or [0.5, 1). The range bit and the seven mantissa bits below the hidden one then index a 256-entry table. That table is computed while the design elaborates. The lower range is sampled in steps of 1/512 and the upper range in steps of 1/256. The result exponent is computed arithmetically from the biased input exponent. Each accepted operand gives one registered result on the following cycle.

Top module: `rsqrt_est`

## Requirements
- R1: In floating mode, a NaN operand (exponent 0xFF, mantissa nonzero) returns 0x7FC00000. It raises invalid only when mantissa bit 22 is 0, meaning the NaN is signalling. Divide-by-zero stays low, and this holds whatever the sign bit is.
- R2: In floating mode, an operand with exponent field 0 returns an infinity carrying the operand's sign and raises divide-by-zero. This covers zero and subnormals of either sign. The two infinities are 0x7F800000 and 0xFF800000.
- R3: In floating mode, a negative operand that is neither zero, subnormal nor NaN returns 0x7FC00000 and raises invalid. Negative infinity falls in this case.
- R4: In floating mode, +infinity (0x7F800000) returns 0x00000000 with both flags low.
- R5: In floating mode, a positive normal operand with biased exponent e gives a result with these fields. Bit 31 is 0. Bits 30:23 hold floor((380 - e)/2). Bits 22:15 hold the low eight bits of the seed s. Bits 14:0 are 0, and both flags are low.
- R6: The floating seed uses q = 128 + operand bits 22:16. When exponent bit 0 (operand bit 23) is 1, s = floor(256/sqrt((q+0.5)/512) + 0.5). When it is 0, s = floor(256/sqrt((q+0.5)/256) + 0.5). The value of s always lies in 256..511.
- R7: In fixed mode (mode = 1), an operand whose bits 31:30 are both 0 returns 0xFFFFFFFF. Both flags stay low for every fixed-mode operand.
- R8: In fixed mode, when bit 31 is 1, q = operand bits 31:24 and the 1/256 step of R6 applies. When bits 31:30 are 01, q = 128 + operand bits 29:23 and the 1/512 step applies. The result is bit 31 set, bits 30:23 holding the low eight bits of s, and bits 22:0 zero.
- R9: A result and its flags appear with out_valid exactly one clock after in_valid is sampled high. While rst_n is low, out_valid, result and both flags are all 0.
- R10: On a cycle where in_valid is low, result and both flags keep their previous values whatever mode and operand carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand and mode are sampled on this cycle |
| mode | input | 1 | 0 = binary32 operand, 1 = unsigned 32-bit fraction |
| operand | input | 32 | Operand word |
| out_valid | output | 1 | Result is new this cycle |
| result | output | 32 | Estimate of 1/sqrt(operand) |
| flag_invalid | output | 1 | Invalid-operation flag (floating mode only) |
| flag_divzero | output | 1 | Divide-by-zero flag (floating mode only) |

## Verification
The bench walks all 256 table entries through the floating port. A table built with the wrong step size for one range, or with the parity sense swapped, would give seeds off by tens of units. The ends of the table are checked directly: 1.0 must give 0x3F7F8000 and 2.0 must give 0x3F348000. Classification is probed at its boundaries, where an ordering mistake shows up as a wrong result or flag:
- NaNs with the sign bit set must not be reported as negative numbers.
- Negative subnormals must give −infinity and not a NaN.
- Quiet and signalling NaNs must differ only in the invalid flag.

Fixed mode is driven on both sides of the bit-31 and bit-30 boundaries. Selecting the wrong seven-bit window there would shift the estimate or drop the all-ones saturation.

// File: rtl/rsqrt_pkg.sv
package rsqrt_pkg;

   typedef enum logic [2:0] {
      CLS_NORMAL,
      CLS_ZERO,
      CLS_POS_INF,
      CLS_NEGATIVE,
      CLS_QNAN,
      CLS_SNAN
   } rsqrt_cls_e;

   // Seed s = round(2^est_w / sqrt((q + 0.5) / scale)), exact integer search.
   // scale = 2^(frac_bits+2) for the low range, 2^(frac_bits+1) for the high range.
   // s is the largest k with (2k-1)^2 * (2q+1) <= 2^(2*est_w+3) * scale.
   function automatic longint seed_value(int est_w, int frac_bits, bit lo_range, int frac);
      longint d;
      longint lim;
      longint k;
      longint t;
      d   = 2 * ((longint'(1) << frac_bits) + longint'(frac)) + 1;
      lim = longint'(1) << (2 * est_w + 3 + frac_bits + (lo_range ? 2 : 1));
      k   = 0;
      for (int b = est_w; b >= 0; b--) begin
         t = k | (longint'(1) << b);
         if ((2 * t - 1) * (2 * t - 1) * d <= lim) k = t;
      end
      return k;
   endfunction

endpackage

// File: rtl/rsqrt_classify.sv
module rsqrt_classify #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   localparam int DATA_W = 1 + EXP_W + MAN_W
) (
   input  logic [DATA_W-1:0]     op,
   output rsqrt_pkg::rsqrt_cls_e cls
);
   import rsqrt_pkg::*;

   logic             sign;
   logic [EXP_W-1:0] expf;
   logic [MAN_W-1:0] manf;

   assign sign = op[DATA_W-1];
   assign expf = op[DATA_W-2 -: EXP_W];
   assign manf = op[MAN_W-1:0];

   always_comb begin
      if (expf == '0) begin
         cls = CLS_ZERO;
      end else if (expf == '1) begin
         if (manf != '0)  cls = manf[MAN_W-1] ? CLS_QNAN : CLS_SNAN;
         else if (sign)   cls = CLS_NEGATIVE;
         else             cls = CLS_POS_INF;
      end else begin
         cls = sign ? CLS_NEGATIVE : CLS_NORMAL;
      end
   end
endmodule

// File: rtl/rsqrt_seed_rom.sv
module rsqrt_seed_rom #(
   parameter int FRAC_BITS = 7,
   parameter int EST_W     = 8,
   localparam int IDX_W    = FRAC_BITS + 1,
   localparam int DEPTH    = 1 << IDX_W
) (
   input  logic [IDX_W-1:0] idx,
   output logic [EST_W-1:0] seed
);
   import rsqrt_pkg::*;

   logic [EST_W-1:0] tbl [DEPTH];

   // Upper index bit selects the low (finer-step) range; the seed MSB is
   // always set, so only the EST_W bits beneath it are kept.
   for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      localparam bit LO   = (i >= (DEPTH / 2));
      localparam int FRAC = i % (DEPTH / 2);
      assign tbl[i] = EST_W'(seed_value(EST_W, FRAC_BITS, LO, FRAC));
   end

   assign seed = tbl[idx];
endmodule

// File: rtl/rsqrt_assemble.sv
module rsqrt_assemble #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   parameter int EST_W = 8,
   localparam int DATA_W = 1 + EXP_W + MAN_W
) (
   input  logic                  mode,
   input  logic                  sign,
   input  logic                  fix_small,
   input  rsqrt_pkg::rsqrt_cls_e cls,
   input  logic [EXP_W-1:0]      res_exp,
   input  logic [EST_W-1:0]      seed,
   output logic [DATA_W-1:0]     res,
   output logic                  inv,
   output logic                  dz
);
   import rsqrt_pkg::*;

   localparam logic [DATA_W-1:0] QNAN_W = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

   always_comb begin
      res = '0;
      inv = 1'b0;
      dz  = 1'b0;
      if (mode) begin
         if (fix_small) res = '1;
         else           res = {1'b1, seed, {(DATA_W-1-EST_W){1'b0}}};
      end else begin
         unique case (cls)
            CLS_NORMAL:   res = {1'b0, res_exp, seed, {(MAN_W-EST_W){1'b0}}};
            CLS_ZERO: begin
               res = {sign, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
               dz  = 1'b1;
            end
            CLS_POS_INF:  res = '0;
            CLS_NEGATIVE: begin
               res = QNAN_W;
               inv = 1'b1;
            end
            CLS_QNAN:     res = QNAN_W;
            CLS_SNAN: begin
               res = QNAN_W;
               inv = 1'b1;
            end
            default:      res = QNAN_W;
         endcase
      end
   end
endmodule

// File: rtl/rsqrt_est.sv
module rsqrt_est #(
   parameter int EXP_W     = 8,
   parameter int MAN_W     = 23,
   parameter int FRAC_BITS = 7,
   parameter int EST_W     = 8,
   parameter int OUT_REG   = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_valid,
   input  logic        mode,
   input  logic [31:0] operand,
   output logic        out_valid,
   output logic [31:0] result,
   output logic        flag_invalid,
   output logic        flag_divzero
);
   import rsqrt_pkg::*;

   localparam int DATA_W = 1 + EXP_W + MAN_W;
   localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
   localparam int EXP_SUM = 3 * BIAS - 1;
   localparam int IDX_W  = FRAC_BITS + 1;

   if (DATA_W != 32) begin : g_bad_width
      $error("rsqrt_est: EXP_W + MAN_W + 1 must equal the 32-bit port width");
   end
   if (EST_W < 4 || EST_W >= MAN_W) begin : g_bad_est
      $error("rsqrt_est: EST_W out of range");
   end
   if (FRAC_BITS < 3 || FRAC_BITS > 10 || FRAC_BITS > MAN_W) begin : g_bad_frac
      $error("rsqrt_est: FRAC_BITS out of range");
   end
   if (OUT_REG != 0 && OUT_REG != 1) begin : g_bad_reg
      $error("rsqrt_est: OUT_REG must be 0 or 1");
   end

   rsqrt_cls_e           cls;
   logic [EXP_W-1:0]     expf;
   logic [EXP_W+1:0]     exp_diff;
   logic [EXP_W-1:0]     res_exp;
   logic                 lo_range;
   logic [FRAC_BITS-1:0] frac;
   logic [EST_W-1:0]     seed;
   logic [DATA_W-1:0]    nxt_res;
   logic                 nxt_inv;
   logic                 nxt_dz;

   rsqrt_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .op  (operand),
      .cls (cls)
   );

   assign expf     = operand[DATA_W-2 -: EXP_W];
   assign exp_diff = (EXP_W+2)'(EXP_SUM) - {2'b00, expf};
   assign res_exp  = EXP_W'(exp_diff >> 1);

   // Range and table window: float uses exponent parity and the top mantissa
   // bits; fixed mode uses bit 31 to pick the window under the leading one.
   always_comb begin
      if (mode) begin
         lo_range = ~operand[DATA_W-1];
         frac     = operand[DATA_W-1] ? operand[DATA_W-2 -: FRAC_BITS]
                                      : operand[DATA_W-3 -: FRAC_BITS];
      end else begin
         lo_range = operand[MAN_W];
         frac     = operand[MAN_W-1 -: FRAC_BITS];
      end
   end

   rsqrt_seed_rom #(.FRAC_BITS(FRAC_BITS), .EST_W(EST_W)) u_rom (
      .idx  ({lo_range, frac}),
      .seed (seed)
   );

   rsqrt_assemble #(.EXP_W(EXP_W), .MAN_W(MAN_W), .EST_W(EST_W)) u_asm (
      .mode      (mode),
      .sign      (operand[DATA_W-1]),
      .fix_small (operand[DATA_W-1 -: 2] == 2'b00),
      .cls       (cls),
      .res_exp   (res_exp),
      .seed      (seed),
      .res       (nxt_res),
      .inv       (nxt_inv),
      .dz        (nxt_dz)
   );

   if (OUT_REG == 1) begin : g_out_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_valid    <= 1'b0;
            result       <= '0;
            flag_invalid <= 1'b0;
            flag_divzero <= 1'b0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               result       <= nxt_res;
               flag_invalid <= nxt_inv;
               flag_divzero <= nxt_dz;
            end
         end
      end
   end else begin : g_out_comb
      assign out_valid    = in_valid & rst_n;
      assign result       = rst_n ? nxt_res : '0;
      assign flag_invalid = rst_n & nxt_inv;
      assign flag_divzero = rst_n & nxt_dz;
   end
endmodule

// File: rtl/rsqrt_est_chk.sv
module rsqrt_est_chk #(
   parameter int LAT = 1
) (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic        mode,
   input logic [31:0] operand,
   input logic        out_valid,
   input logic [31:0] result,
   input logic        flag_invalid,
   input logic        flag_divzero
);
   localparam logic [31:0] QNAN_C = 32'h7FC0_0000;

   // R1
   flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({flag_invalid, flag_divzero}));

   // R3
   invalid_qnan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_invalid |-> result == QNAN_C);

   // R2
   divzero_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_divzero |-> result[30:0] == 31'h7F80_0000);

   if (LAT == 1) begin : g_seq
      // R9
      valid_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);

      // R9
      valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);

      // R10
      result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> $stable(result) && $stable(flag_invalid) && $stable(flag_divzero));

      // R7
      fixed_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid && mode |=> !flag_invalid && !flag_divzero);

      // R7
      fixed_small_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid && mode && operand[31:30] == 2'b00 |=> result == 32'hFFFF_FFFF);

      // R5
      normal_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid && !mode && !operand[31] && operand[30:23] != 8'h00 && operand[30:23] != 8'hFF
         |=> !result[31] && result[14:0] == 15'h0 && !flag_invalid && !flag_divzero);
   end
endmodule

bind rsqrt_est rsqrt_est_chk #(.LAT(OUT_REG)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .mode         (mode),
   .operand      (operand),
   .out_valid    (out_valid),
   .result       (result),
   .flag_invalid (flag_invalid),
   .flag_divzero (flag_divzero)
);

// File: tb/sim_rsqrt_est.sv
module sim_rsqrt_est;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        mode = 1'b0;
   logic [31:0] operand = '0;
   logic        out_valid;
   logic [31:0] result;
   logic        flag_invalid;
   logic        flag_divzero;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   rsqrt_est u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .mode         (mode),
      .operand      (operand),
      .out_valid    (out_valid),
      .result       (result),
      .flag_invalid (flag_invalid),
      .flag_divzero (flag_divzero)
   );

   function automatic int s_model(bit lo, int f7);
      real q;
      real r;
      q = 128.0 + f7;
      r = lo ? 1.0 / $sqrt((q + 0.5) / 512.0) : 1.0 / $sqrt((q + 0.5) / 256.0);
      return $rtoi(256.0 * r + 0.5);
   endfunction

   // returns {invalid, divzero, result}
   function automatic logic [33:0] model(bit m, logic [31:0] op);
      logic [7:0]  e;
      logic [22:0] mn;
      int          s;
      int          ex;
      e  = op[30:23];
      mn = op[22:0];
      if (m) begin
         if (op[31:30] == 2'b00) return {2'b00, 32'hFFFF_FFFF};
         s = op[31] ? s_model(1'b0, int'(op[30:24])) : s_model(1'b1, int'(op[29:23]));
         return {2'b00, 1'b1, s[7:0], 23'h0};
      end
      if (e == 8'hFF && mn != 0) return {~mn[22], 1'b0, 32'h7FC0_0000};
      if (e == 8'h00)            return {2'b01, op[31], 8'hFF, 23'h0};
      if (op[31])                return {2'b10, 32'h7FC0_0000};
      if (e == 8'hFF)            return 34'h0;
      s  = s_model(e[0], int'(mn[22:16]));
      ex = (380 - int'(e)) / 2;
      return {2'b00, 1'b0, ex[7:0], s[7:0], 15'h0};
   endfunction

   function automatic string tag_of(bit m, logic [31:0] op);
      if (m) return (op[31:30] == 2'b00) ? "R7" : "R8";
      if (op[30:23] == 8'hFF && op[22:0] != 0) return "R1";
      if (op[30:23] == 8'h00) return "R2";
      if (op[31]) return "R3";
      if (op[30:23] == 8'hFF) return "R4";
      return "R5";
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic run(bit m, logic [31:0] op, string tag);
      logic [33:0] e;
      logic [31:0] held;
      e = model(m, op);
      @(negedge clk);
      in_valid = 1'b1;
      mode     = m;
      operand  = op;
      @(negedge clk);
      in_valid = 1'b0;
      mode     = ~m;
      operand  = $urandom;
      chk({tag, " result"}, result, e[31:0]);
      chk({tag, " flags"}, {30'h0, flag_invalid, flag_divzero}, {30'h0, e[33:32]});
      chk("R9 out_valid high", {31'h0, out_valid}, 32'h1);
      held = result;
      @(negedge clk);
      chk("R10 result held", result, held);
      chk("R9 out_valid low", {31'h0, out_valid}, 32'h0);
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      // R9 reset state
      chk("R9 reset out_valid", {31'h0, out_valid}, 32'h0);
      chk("R9 reset result", result, 32'h0);
      chk("R9 reset flags", {30'h0, flag_invalid, flag_divzero}, 32'h0);
      rst_n = 1'b1;

      // directed corners
      run(1'b0, 32'h3F80_0000, "R5 one");
      chk("R5 one literal", result, 32'h3F7F_8000);
      run(1'b0, 32'h4000_0000, "R5 two");
      chk("R5 two literal", result, 32'h3F34_8000);
      run(1'b0, 32'h7FC0_0001, "R1 qnan");
      run(1'b0, 32'hFF80_0001, "R1 neg snan");
      run(1'b0, 32'h7F80_0001, "R1 snan");
      run(1'b0, 32'h0000_0000, "R2 +0");
      run(1'b0, 32'h8000_0000, "R2 -0");
      run(1'b0, 32'h8000_0001, "R2 neg subnormal");
      run(1'b0, 32'h007F_FFFF, "R2 pos subnormal");
      run(1'b0, 32'hFF80_0000, "R3 -inf");
      run(1'b0, 32'hBF80_0000, "R3 -1");
      run(1'b0, 32'h7F80_0000, "R4 +inf");
      run(1'b0, 32'h0080_0000, "R5 min normal");
      run(1'b0, 32'h7F7F_FFFF, "R5 max normal");
      run(1'b1, 32'h3FFF_FFFF, "R7 below quarter");
      run(1'b1, 32'h0000_0000, "R7 zero");
      run(1'b1, 32'h4000_0000, "R8 quarter");
      run(1'b1, 32'h7FFF_FFFF, "R8 below half");
      run(1'b1, 32'h8000_0000, "R8 half");
      run(1'b1, 32'hFFFF_FFFF, "R8 top");

      // R6: every table entry through the floating port
      for (int i = 0; i < 256; i++) begin
         logic [7:0]  ex;
         logic [31:0] op;
         ex = (i >= 128) ? 8'd127 : 8'd128;
         op = {1'b0, ex, i[6:0], 16'($urandom)};
         run(1'b0, op, "R6 table");
      end

      // constrained random mix
      for (int n = 0; n < 3000; n++) begin
         logic [31:0] op;
         bit          m;
         int          kind;
         op   = $urandom;
         m    = ($urandom % 4) == 0;
         kind = $urandom % 8;
         if (!m) begin
            case (kind)
               0: op[30:23] = 8'hFF;
               1: op[30:23] = 8'h00;
               2, 3: op[31] = 1'b0;
               default: ;
            endcase
         end else if (kind == 0) begin
            op[31:30] = 2'b00;
         end
         run(m, op, tag_of(m, op));
      end

      finish_up();
   end
endmodule